// File: doc/BRIEF.md
# Double-Buffered Serial Transmit Data Path

This block is the transmit side of a two-wire serial bus controller. The CPU writes a byte into a one-byte holding buffer. Whenever the byte shifter is idle, the buffered byte moves into it. The shifter then sends the byte most significant bit first, one bit per shift-enable pulse. After the data bits it spends one acknowledge slot with the line released high. A buffer-empty flag tells software when the next byte may be written, and it can raise an interrupt request.

The flag responds to several events: CPU writes, buffer-to-shifter transfers, detected bus start and stop conditions, and an internal initialization pulse. CPU access to the data register is gated by a module-enable input. Writes count only while the effective direction is transmit. A request to switch to receive while a byte is on the wire waits until that frame, acknowledge slot included, has finished.

Top module: `txdb_top`

## Requirements
- R1: After synchronous reset, `empty_flag` and `tx_irq` are 0, `sdo` is 1, `rd_data` is 0 and `xmit_active` is 0.
- R2: While `reg_en` is 0, writes change neither the buffer nor the flag, and a read strobe loads 0 into `rd_data`. While `reg_en` is 1, a read strobe loads the buffer byte into `rd_data` on the next edge.
- R3: A write in transmit mode clears `empty_flag` on the next edge. If the shifter is idle, the byte moves into the shifter on the following edge, which sets the flag again. The flag is therefore low for exactly one cycle.
- R4: Every transfer from buffer to shifter sets `empty_flag`. A byte written while the shifter is busy waits in the buffer, with the flag low, until the frame completes. It then transfers one cycle later.
- R5: A `bus_start` pulse sets `empty_flag` on the next edge.
- R6: A `bus_stop` pulse clears `empty_flag` on the next edge. It wins over a start or a transfer in the same cycle.
- R7: A write that coincides with a `bus_start` pulse leaves the flag cleared.
- R8: While the effective direction is receive (`xmit_active` = 0), writes leave the buffer contents and the flag unchanged.
- R9: On a load, `sdo` shows bit 7 of the byte. Each `shift_en` pulse advances by one bit, MSB first. After 8 pulses, `sdo` is 1 for the acknowledge slot. The ninth pulse ends the frame and frees the shifter. `sdo` is 1 whenever the shifter is idle.
- R10: `xmit_active` follows `tx_mode_req` while the shifter is idle. While a frame is in progress, it changes only on the pulse that ends the frame.
- R11: An `int_init` pulse clears the flag, discards a pending buffered byte and returns the shifter to idle with `sdo` = 1.
- R12: `tx_irq` is registered. It is 1 exactly when `empty_flag` is 1 and `tx_ie` was 1 in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_en | input | 1 | Module enable for data register access |
| wr_stb | input | 1 | Data register write strobe |
| wr_data | input | 8 | Write data |
| rd_stb | input | 1 | Data register read strobe |
| rd_data | output | 8 | Registered read data |
| tx_mode_req | input | 1 | Requested direction, 1 = transmit |
| bus_start | input | 1 | Start condition detected pulse |
| bus_stop | input | 1 | Stop condition detected pulse |
| int_init | input | 1 | Internal state initialization pulse |
| shift_en | input | 1 | Advance shifter by one bit slot |
| tx_ie | input | 1 | Transmit interrupt enable |
| xmit_active | output | 1 | Effective direction, 1 = transmit |
| empty_flag | output | 1 | Transmit buffer empty flag |
| tx_irq | output | 1 | Interrupt request |
| sdo | output | 1 | Serial data out |

## Verification
Some behaviour holds on every cycle, and the assertions check it there. They check how the flag responds to each event (write, transfer, start, stop, init) and its priority ordering. They also check that the interrupt never rises without the flag, that `sdo` stays high during the acknowledge slot and at idle, and that the effective direction holds steady through a frame. Other behaviour needs a defined sequence, and only the bench scenarios show it. These are the one-cycle flag dip on a write into an idle shifter, the MSB-first bit order of a known byte, and a pending byte waiting exactly until the ninth shift pulse. The bench also shows that receive-mode and disabled writes leave the buffer intact, as seen by reading it back, and that an init pulse discards a pending byte.

// File: rtl/txdb_pkg.sv
package txdb_pkg;

  typedef struct packed {
    logic start;
    logic stop;
    logic init;
  } bus_evt_t;

  // Clearing events outrank setting events; write outranks start.
  function automatic logic flag_next(input logic cur, input logic wr_ok,
                                     input logic xfer, input bus_evt_t ev);
    if (ev.init || wr_ok || ev.stop) return 1'b0;
    if (xfer || ev.start)            return 1'b1;
    return cur;
  endfunction

endpackage

// File: rtl/txdb_shifter.sv
module txdb_shifter #(
  parameter int DATA_W    = 8,
  parameter int ACK_SLOTS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              shift_en,
  output logic              busy,
  output logic              last_shift,
  output logic              sdo
);
  localparam int TOTAL = DATA_W + ACK_SLOTS;
  localparam int CNT_W = $clog2(TOTAL + 1);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(TOTAL - 1);
  localparam logic [CNT_W-1:0] ACK_FROM  = CNT_W'(DATA_W);

  logic [DATA_W-1:0] sh_q;
  logic [CNT_W-1:0]  cnt_q;

  assign last_shift = busy && shift_en && (cnt_q == LAST_SLOT);
  assign sdo        = sh_q[DATA_W-1];

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      sh_q  <= '1;
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (load && !busy) begin
      sh_q  <= load_data;
      busy  <= 1'b1;
      cnt_q <= '0;
    end else if (busy && shift_en) begin
      sh_q <= {sh_q[DATA_W-2:0], 1'b1};
      if (cnt_q == LAST_SLOT) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R9
  load_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !busy && !abort) |=> busy);
  // R9
  ack_high_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt_q >= ACK_FROM) |-> sdo);
  // R9
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> sdo);
  // R11
  abort_idle_chk: assert property (@(posedge clk) disable iff (rst)
    abort |=> (!busy && sdo));

endmodule

// File: rtl/txdb_mode_ctl.sv
module txdb_mode_ctl (
  input  logic clk,
  input  logic rst,
  input  logic tx_mode_req,
  input  logic sh_busy,
  input  logic last_shift,
  output logic xmit_active
);
  always_ff @(posedge clk) begin
    if (rst)
      xmit_active <= 1'b0;
    else if (!sh_busy || last_shift)
      xmit_active <= tx_mode_req;
  end

  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sh_busy && !last_shift) |=> $stable(xmit_active));

endmodule

// File: rtl/txdb_hold_buf.sv
module txdb_hold_buf
  import txdb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  input  logic              xmit,
  input  bus_evt_t          ev,
  input  logic              sh_busy,
  input  logic              tx_ie,
  output logic              load,
  output logic [DATA_W-1:0] load_data,
  output logic              flag,
  output logic              irq,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] buf_q;
  logic              valid_q;
  logic              wr_ok;
  logic              flag_d;

  assign wr_ok     = wr_stb && reg_en && xmit;
  assign load      = valid_q && !sh_busy && !ev.init;
  assign load_data = buf_q;
  assign flag_d    = flag_next(flag, wr_ok, load, ev);

  always_ff @(posedge clk) begin
    if (rst) begin
      buf_q   <= '0;
      valid_q <= 1'b0;
      flag    <= 1'b0;
      irq     <= 1'b0;
      rd_data <= '0;
    end else begin
      if (wr_ok) buf_q <= wr_data;
      if (ev.init)    valid_q <= 1'b0;
      else if (wr_ok) valid_q <= 1'b1;
      else if (load)  valid_q <= 1'b0;
      flag <= flag_d;
      irq  <= flag_d && tx_ie;
      if (rd_stb) rd_data <= reg_en ? buf_q : '0;
    end
  end

  // R3
  wr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    wr_ok |=> !flag);
  // R4
  xfer_set_chk: assert property (@(posedge clk) disable iff (rst)
    (load && !wr_ok && !ev.stop && !ev.init) |=> flag);
  // R5
  start_set_chk: assert property (@(posedge clk) disable iff (rst)
    (ev.start && !wr_ok && !ev.stop && !ev.init) |=> flag);
  // R6
  stop_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ev.stop |=> !flag);
  // R11
  init_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ev.init |=> !flag);
  // R8
  ignored_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !wr_ok && !load && !ev.start && !ev.stop && !ev.init) |=> $stable(flag));
  // R2
  rd_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_stb && !reg_en) |=> (rd_data == '0));
  // R12
  irq_flag_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> flag);

endmodule

// File: rtl/txdb_top.sv
module txdb_top
  import txdb_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int ACK_SLOTS = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_en,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_stb,
  output logic [DATA_W-1:0] rd_data,
  input  logic              tx_mode_req,
  input  logic              bus_start,
  input  logic              bus_stop,
  input  logic              int_init,
  input  logic              shift_en,
  input  logic              tx_ie,
  output logic              xmit_active,
  output logic              empty_flag,
  output logic              tx_irq,
  output logic              sdo
);
  bus_evt_t          ev;
  logic              load;
  logic [DATA_W-1:0] load_data;
  logic              sh_busy;
  logic              last_shift;

  assign ev = '{start: bus_start, stop: bus_stop, init: int_init};

  txdb_hold_buf #(.DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst), .reg_en(reg_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .xmit(xmit_active), .ev(ev), .sh_busy(sh_busy), .tx_ie(tx_ie),
    .load(load), .load_data(load_data), .flag(empty_flag), .irq(tx_irq),
    .rd_data(rd_data)
  );

  txdb_shifter #(.DATA_W(DATA_W), .ACK_SLOTS(ACK_SLOTS)) u_sh (
    .clk(clk), .rst(rst), .abort(int_init), .load(load), .load_data(load_data),
    .shift_en(shift_en), .busy(sh_busy), .last_shift(last_shift), .sdo(sdo)
  );

  txdb_mode_ctl u_mode (
    .clk(clk), .rst(rst), .tx_mode_req(tx_mode_req), .sh_busy(sh_busy),
    .last_shift(last_shift), .xmit_active(xmit_active)
  );

endmodule

// File: tb/txdb_top_test.sv
module txdb_top_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       reg_en = 1'b1, wr_stb = 1'b0, rd_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       tx_mode_req = 1'b0, bus_start = 1'b0, bus_stop = 1'b0;
  logic       int_init = 1'b0, shift_en = 1'b0, tx_ie = 1'b0;
  logic       xmit_active, empty_flag, tx_irq, sdo;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  txdb_top uut (
    .clk(clk), .rst(rst), .reg_en(reg_en), .wr_stb(wr_stb), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_data(rd_data), .tx_mode_req(tx_mode_req),
    .bus_start(bus_start), .bus_stop(bus_stop), .int_init(int_init),
    .shift_en(shift_en), .tx_ie(tx_ie), .xmit_active(xmit_active),
    .empty_flag(empty_flag), .tx_irq(tx_irq), .sdo(sdo)
  );

  task automatic step(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clean();
    rst = 1'b1; tx_mode_req = 1'b1; reg_en = 1'b1; tx_ie = 1'b0;
    step();
    rst = 1'b0;
    step();
  endtask

  task automatic wr(logic [7:0] d);
    wr_stb = 1'b1; wr_data = d; step(); wr_stb = 1'b0;
  endtask

  task automatic rd();
    rd_stb = 1'b1; step(); rd_stb = 1'b0;
  endtask

  task automatic shift(int n);
    repeat (n) begin shift_en = 1'b1; step(); shift_en = 1'b0; end
  endtask

  task automatic t_reset();
    rst = 1'b1; step(); rst = 1'b0;
    chk("R1 flag", empty_flag, 0);
    chk("R1 irq", tx_irq, 0);
    chk("R1 sdo", sdo, 1);
    chk("R1 rd_data", rd_data, 0);
    chk("R1 xmit_active", xmit_active, 0);
  endtask

  task automatic t_write_idle();
    clean();
    wr(8'hC3);
    chk("R3 flag dips after write", empty_flag, 0);
    step();
    chk("R3 flag back after transfer", empty_flag, 1);
    chk("R4 shifter loaded msb", sdo, 1);
  endtask

  task automatic t_shift_order();
    logic [7:0] b = 8'hA5;
    clean();
    wr(b); step();
    for (int i = 0; i < 8; i++) begin
      chk("R9 bit order", sdo, b[7-i]);
      shift(1);
    end
    chk("R9 ack slot high", sdo, 1);
    wr(8'h00); step();
    chk("R9 still busy in ack slot", empty_flag, 0);
    shift(1);
    chk("R4 no transfer on final shift edge", empty_flag, 0);
    step();
    chk("R4 pending byte transfers", empty_flag, 1);
    chk("R9 next byte msb", sdo, 0);
  endtask

  task automatic t_start_stop();
    clean();
    bus_start = 1'b1; step(); bus_start = 1'b0;
    chk("R5 start sets flag", empty_flag, 1);
    bus_stop = 1'b1; step(); bus_stop = 1'b0;
    chk("R6 stop clears flag", empty_flag, 0);
    bus_start = 1'b1; step(); bus_start = 1'b0;
    bus_start = 1'b1; bus_stop = 1'b1; step(); bus_start = 1'b0; bus_stop = 1'b0;
    chk("R6 stop beats start", empty_flag, 0);
  endtask

  task automatic t_write_start();
    clean();
    wr(8'h11); step();
    chk("R7 setup flag", empty_flag, 1);
    bus_start = 1'b1; wr(8'h22); bus_start = 1'b0;
    chk("R7 write beats start", empty_flag, 0);
    step(2);
    chk("R4 pending waits while busy", empty_flag, 0);
  endtask

  task automatic t_enable_gate();
    clean();
    wr(8'hA5); step();
    reg_en = 1'b0;
    wr(8'h3C);
    chk("R2 disabled write keeps flag", empty_flag, 1);
    rd();
    chk("R2 disabled read zero", rd_data, 0);
    reg_en = 1'b1;
    rd();
    chk("R2 buffer unchanged", rd_data, 8'hA5);
  endtask

  task automatic t_mode_defer();
    clean();
    wr(8'h81); step();
    tx_mode_req = 1'b0; step();
    chk("R10 mode held during frame", xmit_active, 1);
    shift(8);
    chk("R10 mode held in ack slot", xmit_active, 1);
    shift(1);
    chk("R10 mode switches at frame end", xmit_active, 0);
    wr(8'h55);
    chk("R8 rx write keeps flag", empty_flag, 1);
    rd();
    chk("R8 rx write keeps buffer", rd_data, 8'h81);
    step(2);
    chk("R8 no transfer from rx write", empty_flag, 1);
    tx_mode_req = 1'b1; step();
    chk("R10 idle mode follows request", xmit_active, 1);
  endtask

  task automatic t_init();
    clean();
    wr(8'h0F); step();
    chk("R9 loaded msb zero", sdo, 0);
    wr(8'h99);
    int_init = 1'b1; step(); int_init = 1'b0;
    chk("R11 init clears flag", empty_flag, 0);
    chk("R11 init idles shifter", sdo, 1);
    step(3);
    chk("R11 pending byte discarded", empty_flag, 0);
    wr(8'h40); step();
    chk("R11 shifter idle after init", empty_flag, 1);
    chk("R11 new byte loaded", sdo, 0);
  endtask

  task automatic t_irq();
    clean();
    tx_ie = 1'b1;
    bus_start = 1'b1; step(); bus_start = 1'b0;
    chk("R12 irq with flag", tx_irq, 1);
    tx_ie = 1'b0; step();
    chk("R12 irq off when disabled", tx_irq, 0);
    chk("R12 flag still set", empty_flag, 1);
    tx_ie = 1'b1; bus_stop = 1'b1; step(); bus_stop = 1'b0;
    chk("R12 irq follows cleared flag", tx_irq, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #1;
    t_reset();
    t_write_idle();
    t_shift_order();
    t_start_stop();
    t_write_start();
    t_enable_gate();
    t_mode_defer();
    t_init();
    t_irq();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule